// File: doc/BRIEF.md
# Two-Tier Inverter Trip Sequencer

This block sits between a PWM generator and the four gate drives of one three-level inverter leg. Positions 0 and 3 are the outer switches and positions 1 and 2 are the inner switches. Two external fault lines feed the block. The mild tier shuts only the outer pair. The severe tier shuts the outer pair at once and then, after a programmable number of clocks, shuts the inner pair as well. Each fault line can be inverted, so active-low board signals become active-high inside the block. Both lines are synchronised before any logic uses them.

The outer-pair block works cycle by cycle. Either tier sets it, and it stays set until the next PWM period-start strobe arrives while neither tier is active. The inner-pair shutdown is a separate latch. A clear pulse releases it, but only while the severe tier is inactive. If the severe tier goes away before the delay runs out, the pending shutdown is dropped and the timer goes back to idle.

A small parallel write port loads the delay and the polarity bits. Three status outputs report the state of the protection: outer blocked, inner shutdown pending, and inner shutdown latched.

Top module: `tiered_trip_seq`

## Requirements
- R1: While `rst_n` is low, all four gate outputs are low and all status outputs are low. After reset, the delay is 0 and both invert bits are 1, so a raw fault line is active when low.
- R2: A mild-tier fault drives `gate_out[0]` and `gate_out[3]` low. Meanwhile `gate_out[1]` and `gate_out[2]` keep following `pwm_in[1]` and `pwm_in[2]`.
- R3: The two tiers are OR'ed into one outer-block source. After the raw assertion edge of either tier, or of both together, `outer_blocked` is high and the outer gates are low exactly SYNC_STAGES clocks later.
- R4: Once set, `outer_blocked` stays high after both tiers clear. It falls only on the clock edge where `period_start` is high and neither tier is active. A `period_start` pulse while a tier is active has no effect.
- R5: Write address 1 holds the polarity bits: bit 0 inverts the mild tier and bit 1 inverts the severe tier. With a bit set to 0, a raw high level is the active level for that tier.
- R6: After the severe tier's assertion edge with programmed delay D, the inner gates go low and `inner_tripped` rises exactly SYNC_STAGES+1+D clocks after the raw edge. They are not low one clock earlier. D = 0 gives SYNC_STAGES+1.
- R7: If the severe tier deasserts before the delay expires, `inner_pending` falls. No inner shutdown follows, and the inner gates keep following the PWM.
- R8: `inner_tripped` stays high until `inner_clr` is seen high while the severe tier is inactive. A clear while the tier is still active is ignored.
- R9: `inner_pending` is high only while the delay is counting, and it is never high together with `inner_tripped`.
- R10: Write address 0 loads the delay from the low DLY_W bits of `cfg_wdata`. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 4 | Raw PWM per switch position (0,3 outer; 1,2 inner) |
| fault_mild_raw | input | 1 | Raw mild-tier fault line |
| fault_sev_raw | input | 1 | Raw severe-tier fault line |
| period_start | input | 1 | PWM period-start strobe |
| inner_clr | input | 1 | Clear pulse for the inner shutdown latch |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration write address |
| cfg_wdata | input | CFG_W | Configuration write data |
| gate_out | output | 4 | Gated switch drives, low = off |
| outer_blocked | output | 1 | Outer pair blocked |
| inner_pending | output | 1 | Inner shutdown delay running |
| inner_tripped | output | 1 | Inner shutdown latched |

## Verification
The bench builds the block with DLY_W = 10 and the default two synchroniser stages. The narrow delay field makes the largest delay (1023) reachable in a short run, and writing 16'hFFFF also checks that the upper data bits are dropped. With two sync stages, every expected transition falls at a fixed clock offset from the raw edge. The tests cover delays of 0, 1, 7 and 1023 in exact cycle counts, a cancel partway through the count, a polarity flip, and both tiers asserting together.

// File: rtl/tts_pkg.sv
package tts_pkg;
   localparam int unsigned POS_OUT_HI = 0;
   localparam int unsigned POS_IN_HI  = 1;
   localparam int unsigned POS_IN_LO  = 2;
   localparam int unsigned POS_OUT_LO = 3;
   localparam int unsigned NUM_POS    = 4;

   localparam logic [1:0] ADDR_DELAY = 2'd0;
   localparam logic [1:0] ADDR_POL   = 2'd1;

   localparam int unsigned TIER_MILD = 0;
   localparam int unsigned TIER_SEV  = 1;
   localparam int unsigned NUM_TIERS = 2;

   typedef enum logic [1:0] {
      IST_IDLE  = 2'd0,
      IST_COUNT = 2'd1,
      IST_SHUT  = 2'd2
   } inner_st_t;
endpackage

// File: rtl/tts_cfg_regs.sv
module tts_cfg_regs
   import tts_pkg::*;
#(
   parameter int unsigned DLY_W = 16,
   parameter int unsigned CFG_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [1:0]           addr,
   input  logic [CFG_W-1:0]     wdata,
   output logic [DLY_W-1:0]     delay_q,
   output logic [NUM_TIERS-1:0] invert_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         delay_q  <= '0;
         invert_q <= '1;
      end else if (we) begin
         case (addr)
            ADDR_DELAY: delay_q  <= wdata[DLY_W-1:0];
            ADDR_POL:   invert_q <= wdata[NUM_TIERS-1:0];
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/tts_trip_cond.sv
module tts_trip_cond #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic invert,
   output logic active,
   output logic assert_edge
);
   logic [STAGES-1:0] sr;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[0] <= 1'b1;
               else        sr[0] <= raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr[i] <= 1'b1;
               else        sr[i] <= sr[i-1];
            end
         end
      end
   endgenerate

   assign active = sr[STAGES-1] ^ invert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= active;
   end

   assign assert_edge = active & ~prev_q;
endmodule

// File: rtl/tts_outer_cbc.sv
module tts_outer_cbc (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_any,
   input  logic period_start,
   output logic blocked
);
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hold_q <= 1'b0;
      else if (trip_any)     hold_q <= 1'b1;
      else if (period_start) hold_q <= 1'b0;
   end

   assign blocked = hold_q | trip_any;
endmodule

// File: rtl/tts_inner_timer.sv
module tts_inner_timer
   import tts_pkg::*;
#(
   parameter int unsigned DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sev_active,
   input  logic             sev_edge,
   input  logic [DLY_W-1:0] delay,
   input  logic             clr,
   output logic             pending,
   output logic             shut
);
   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   inner_st_t        st_q;
   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= IST_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            IST_IDLE: begin
               if (sev_edge) begin
                  cnt_q <= delay;
                  st_q  <= (delay == '0) ? IST_SHUT : IST_COUNT;
               end
            end
            IST_COUNT: begin
               if (!sev_active)      st_q  <= IST_IDLE;
               else if (cnt_q == ONE) st_q <= IST_SHUT;
               else                  cnt_q <= cnt_q - ONE;
            end
            IST_SHUT: begin
               if (clr && !sev_active) st_q <= IST_IDLE;
            end
            default: st_q <= IST_IDLE;
         endcase
      end
   end

   assign pending = (st_q == IST_COUNT);
   assign shut    = (st_q == IST_SHUT);
endmodule

// File: rtl/tiered_trip_seq.sv
module tiered_trip_seq
   import tts_pkg::*;
#(
   parameter int unsigned DLY_W       = 16,
   parameter int unsigned CFG_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       pwm_in,
   input  logic             fault_mild_raw,
   input  logic             fault_sev_raw,
   input  logic             period_start,
   input  logic             inner_clr,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [3:0]       gate_out,
   output logic             outer_blocked,
   output logic             inner_pending,
   output logic             inner_tripped
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DLY_W < 1 || DLY_W > CFG_W) begin : g_bad_dly
         $error("DLY_W must be in 1..CFG_W");
      end
      if (CFG_W < NUM_TIERS) begin : g_bad_cfg
         $error("CFG_W too narrow for polarity bits");
      end
   endgenerate

   logic [DLY_W-1:0]     delay_q;
   logic [NUM_TIERS-1:0] invert_q;
   logic [NUM_TIERS-1:0] raw_vec;
   logic [NUM_TIERS-1:0] act_vec;
   logic [NUM_TIERS-1:0] edge_vec;
   logic                 trip_any;
   logic                 blk;
   logic                 pend;
   logic                 shut;

   assign raw_vec[TIER_MILD] = fault_mild_raw;
   assign raw_vec[TIER_SEV]  = fault_sev_raw;

   tts_cfg_regs #(.DLY_W(DLY_W), .CFG_W(CFG_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .delay_q  (delay_q),
      .invert_q (invert_q)
   );

   generate
      for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
         tts_trip_cond #(.STAGES(SYNC_STAGES)) u_cond (
            .clk         (clk),
            .rst_n       (rst_n),
            .raw         (raw_vec[t]),
            .invert      (invert_q[t]),
            .active      (act_vec[t]),
            .assert_edge (edge_vec[t])
         );
      end
   endgenerate

   assign trip_any = |act_vec;

   tts_outer_cbc u_cbc (
      .clk          (clk),
      .rst_n        (rst_n),
      .trip_any     (trip_any),
      .period_start (period_start),
      .blocked      (blk)
   );

   tts_inner_timer #(.DLY_W(DLY_W)) u_inner (
      .clk        (clk),
      .rst_n      (rst_n),
      .sev_active (act_vec[TIER_SEV]),
      .sev_edge   (edge_vec[TIER_SEV]),
      .delay      (delay_q),
      .clr        (inner_clr),
      .pending    (pend),
      .shut       (shut)
   );

   always_comb begin
      gate_out = '0;
      if (rst_n) begin
         gate_out[POS_OUT_HI] = pwm_in[POS_OUT_HI] & ~blk;
         gate_out[POS_OUT_LO] = pwm_in[POS_OUT_LO] & ~blk;
         gate_out[POS_IN_HI]  = pwm_in[POS_IN_HI]  & ~shut;
         gate_out[POS_IN_LO]  = pwm_in[POS_IN_LO]  & ~shut;
      end
   end

   assign outer_blocked = blk & rst_n;
   assign inner_pending = pend & rst_n;
   assign inner_tripped = shut & rst_n;
endmodule

// File: rtl/tts_chk.sv
module tts_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] pwm_in,
   input logic [3:0] gate_out,
   input logic       period_start,
   input logic       inner_clr,
   input logic       outer_blocked,
   input logic       inner_pending,
   input logic       inner_tripped
);
   // R2
   outer_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      outer_blocked |-> (gate_out[0] == 1'b0 && gate_out[3] == 1'b0));

   // R2
   inner_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inner_tripped |-> (gate_out[2:1] == pwm_in[2:1]));

   // R4
   release_at_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(outer_blocked) |-> $past(period_start));

   // R8
   inner_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inner_tripped |-> (gate_out[2:1] == 2'b00));

   // R8
   clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(inner_tripped) |-> $past(inner_clr));

   // R9
   state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(inner_pending && inner_tripped));

   // R3
   shut_implies_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inner_tripped) |-> outer_blocked);
endmodule

bind tiered_trip_seq tts_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pwm_in        (pwm_in),
   .gate_out      (gate_out),
   .period_start  (period_start),
   .inner_clr     (inner_clr),
   .outer_blocked (outer_blocked),
   .inner_pending (inner_pending),
   .inner_tripped (inner_tripped)
);

// File: tb/sim_tiered_trip_seq.sv
`timescale 1ns/1ps
module sim_tiered_trip_seq;
   localparam int unsigned DLY_W = 10;
   localparam int unsigned CFG_W = 16;
   localparam int unsigned SYNC  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       pwm_in = 4'hF;
   logic             fault_mild_raw = 1'b1;
   logic             fault_sev_raw = 1'b1;
   logic             period_start = 1'b0;
   logic             inner_clr = 1'b0;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_addr = 2'd0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic [3:0]       gate_out;
   logic             outer_blocked, inner_pending, inner_tripped;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   tiered_trip_seq #(.DLY_W(DLY_W), .CFG_W(CFG_W), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
      .fault_mild_raw(fault_mild_raw), .fault_sev_raw(fault_sev_raw),
      .period_start(period_start), .inner_clr(inner_clr),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .gate_out(gate_out), .outer_blocked(outer_blocked),
      .inner_pending(inner_pending), .inner_tripped(inner_tripped)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [CFG_W-1:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      step(1);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_ps();
      period_start = 1'b1; step(1); period_start = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; fault_mild_raw = 1'b1; fault_sev_raw = 1'b1;
      period_start = 1'b0; inner_clr = 1'b0; cfg_we = 1'b0; pwm_in = 4'hF;
      step(3);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; pwm_in = 4'hF;
      step(3);
      chk("R1 gates low in reset", gate_out, 4'h0);
      chk("R1 status low in reset", {outer_blocked, inner_pending, inner_tripped}, 3'b000);
      rst_n = 1'b1;
      step(1);
      chk("R1 gates follow pwm after reset", gate_out, 4'hF);
   endtask

   task automatic t_mild();
      do_reset();
      pwm_in = 4'b1111;
      fault_mild_raw = 1'b0;
      step(SYNC - 1);
      chk("R3 mild not yet blocked", gate_out, 4'hF);
      step(1);
      chk("R2 mild outer off inner on", gate_out, 4'b0110);
      chk("R9 mild blocked status", {outer_blocked, inner_pending, inner_tripped}, 3'b100);
      pwm_in = 4'b1010;
      step(1);
      chk("R2 inner follows pwm pattern", gate_out, 4'b0010);
      pulse_ps();
      chk("R4 period start ignored while active", outer_blocked, 1'b1);
      fault_mild_raw = 1'b1;
      step(SYNC + 3);
      chk("R4 block holds after clear", outer_blocked, 1'b1);
      pulse_ps();
      chk("R4 released at period start", outer_blocked, 1'b0);
      chk("R4 gates restored", gate_out, 4'b1010);
   endtask

   task automatic t_sev(input logic [CFG_W-1:0] wdata, input int d);
      do_reset();
      wr(tts_pkg::ADDR_DELAY, wdata);
      pwm_in = 4'hF;
      fault_sev_raw = 1'b0;
      step(SYNC);
      chk("R3 sev outer off at once", gate_out, 4'b0110);
      if (d > 0) begin
         step(d);
         chk("R6 inner still on one cycle early", gate_out, 4'b0110);
         chk("R9 pending during count", {inner_pending, inner_tripped}, 2'b10);
         step(1);
      end else begin
         chk("R6 zero delay not yet", inner_tripped, 1'b0);
         step(1);
      end
      chk("R6 inner off at delay", gate_out, 4'b0000);
      chk("R9 tripped status", {inner_pending, inner_tripped}, 2'b01);
      inner_clr = 1'b1; step(1); inner_clr = 1'b0;
      chk("R8 clear ignored while sev active", inner_tripped, 1'b1);
      fault_sev_raw = 1'b1;
      step(SYNC + 1);
      chk("R8 stays latched after sev clears", inner_tripped, 1'b1);
      inner_clr = 1'b1; step(1); inner_clr = 1'b0;
      chk("R8 cleared", inner_tripped, 1'b0);
      chk("R8 inner follow after clear", gate_out, 4'b0110);
      pulse_ps();
      chk("R4 outer released", gate_out, 4'hF);
   endtask

   task automatic t_cancel();
      do_reset();
      wr(tts_pkg::ADDR_DELAY, 16'd20);
      pwm_in = 4'b0111;
      fault_sev_raw = 1'b0;
      step(10);
      chk("R7 pending before cancel", inner_pending, 1'b1);
      fault_sev_raw = 1'b1;
      step(SYNC + 1);
      chk("R7 pending dropped", inner_pending, 1'b0);
      step(30);
      chk("R7 no inner shutdown", inner_tripped, 1'b0);
      chk("R7 inner follows pwm", gate_out, 4'b0110);
   endtask

   task automatic t_both();
      do_reset();
      wr(tts_pkg::ADDR_DELAY, 16'd3);
      pwm_in = 4'hF;
      fault_mild_raw = 1'b0; fault_sev_raw = 1'b0;
      step(SYNC);
      chk("R3 both tiers outer off", gate_out, 4'b0110);
      fault_mild_raw = 1'b1;
      step(SYNC + 2);
      chk("R3 inner off with both tiers", gate_out, 4'b0000);
   endtask

   task automatic t_polarity();
      do_reset();
      wr(tts_pkg::ADDR_DELAY, 16'd50);
      fault_mild_raw = 1'b0; fault_sev_raw = 1'b0;
      wr(tts_pkg::ADDR_POL, 16'h0000);
      step(4);
      pulse_ps();
      chk("R5 low raw inactive after flip", outer_blocked, 1'b0);
      chk("R5 no pending after flip", inner_pending, 1'b0);
      fault_mild_raw = 1'b1;
      step(SYNC);
      chk("R5 high raw active after flip", gate_out, 4'b0110);
   endtask

   task automatic t_addr();
      do_reset();
      wr(tts_pkg::ADDR_DELAY, 16'd4);
      wr(2'd2, 16'h0000);
      wr(2'd3, 16'h0000);
      fault_sev_raw = 1'b0;
      step(SYNC + 4);
      chk("R10 unused address kept delay", inner_tripped, 1'b0);
      step(1);
      chk("R10 delay 4 honoured", inner_tripped, 1'b1);
      chk("R10 polarity unchanged", outer_blocked, 1'b1);
   endtask

   initial begin
      #(4 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_mild();
      t_sev(16'd0, 0);
      t_sev(16'd1, 1);
      t_sev(16'd7, 7);
      t_sev(16'hFFFF, 1023);
      t_cancel();
      t_both();
      t_polarity();
      t_addr();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule